// File: doc/BRIEF.md
# Indexed Block-Transfer I2C Register Slave

This block is a two-wire serial slave that fronts a small byte-wide configuration register file. The host never moves a single byte by itself. Every access names a starting index, and the index then steps forward by one after each data byte. A write carries an explicit byte count after the index. A read is opened with a write-direction header that loads the index, then a repeated START with the read address. The slave first returns the current value of a writable count register, then data bytes taken from the index onward.

The system clock samples both bus lines through a two-stage synchronizer. START and STOP are recognised as SDA edges while SCL is high. The slave drives the bus only through an open-drain pull-low enable. Each accepted register write is also shown on a one-cycle write-strobe port, so that neighbouring logic can follow configuration changes. Two identification bytes are fixed and cannot be written. Indices past the implemented file read as zero and absorb writes.

Top module: `i2cx_regslave`

## Requirements
- R1: After reset the SDA pull-low enable is off and no write strobe is raised.
- R2: In a write transfer the slave acknowledges the address byte 0xD2 (7-bit address 0x69, direction bit 0), the index byte, the count byte, and each data byte up to the count.
- R3: After the index header, a repeated START with address byte 0xD3 is acknowledged. The slave then sends the count byte followed by data bytes from the index onward, most significant bit first.
- R4: The index advances by one after each data byte. Each data byte written to a writable location produces one single-cycle strobe carrying its index and data.
- R5: Index 8 is the read-count register. It resets to 0x0F, and a write to it sets both the count byte and the number of data bytes that later reads return.
- R6: Index 7 reads 0x28 and index 6 reads 0x01.
- R7: Data written to index 6 or 7 is acknowledged but leaves them unchanged and raises no strobe.
- R8: Once a read has returned as many data bytes as the count register held, the slave leaves SDA released, so the host reads 0xFF.
- R9: A data byte beyond the write count is not acknowledged and is not written.
- R10: An address byte other than 0xD2/0xD3 is not acknowledged, and the slave keeps SDA released until the next START or STOP.
- R11: Indices 24 to 255 read as 0x00, and writes to them are acknowledged but discarded. The index wraps from 255 to 0.
- R12: A STOP at any point returns the slave to idle without writing a partly received byte. A START at any point restarts the address phase.
- R13: A host NACK after a read byte ends the read, and the slave drives nothing until the next START or STOP.
- R14: The pull-low enable changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_we | output | 1 | Single-cycle strobe for an accepted register write |
| reg_widx | output | 8 | Index of the written register |
| reg_wdata | output | 8 | Byte written |

## Verification
The bench builds the block with its defaults: 24 registers, slave address 0x69, the count register at index 8 with 0x0F, and the identification bytes at 6 and 7. With these sizes a four-byte write from index 22 runs off the end of the file. A write from index 255 exercises the wrap to 0, and lowering the count to 2 makes the released-bus tail of a read appear after only two data bytes. The host model sends wrong addresses, over-long writes and a STOP in the middle of a byte. It also cuts reads short with a NACK.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ADDR,
        PH_INDEX,
        PH_COUNT,
        PH_WDATA,
        PH_ACK,
        PH_TX,
        PH_TXACK,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        phase_e     ph;
        phase_e     nxt_ph;
        logic [2:0] bitn;
        logic       full;
        logic [7:0] shreg;
        logic [7:0] idx;
        logic [7:0] rem;
        logic       oe;
        logic       we;
        logic [7:0] widx;
        logic [7:0] wdata;
    } core_s;

endpackage

// File: rtl/i2cx_sync.sv
module i2cx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
    logic              scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
            sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_pipe_q[STAGES-1];
            sda_prev_q <= sda_pipe_q[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe_q[STAGES-1];
    assign sda_s     = sda_pipe_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    // SDA moving while SCL stays high frames a transfer
    assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/i2cx_regs.sv
module i2cx_regs #(
    parameter int unsigned REG_COUNT  = 24,
    parameter int unsigned COUNT_IDX  = 8,
    parameter logic [7:0]  COUNT_INIT = 8'h0F,
    parameter int unsigned RO_IDX0    = 6,
    parameter int unsigned RO_IDX1    = 7,
    parameter logic [7:0]  RO_VAL0    = 8'h01,
    parameter logic [7:0]  RO_VAL1    = 8'h28
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] widx,
    input  logic [7:0] wdata,
    input  logic [7:0] rd_idx,
    output logic [7:0] rd_data,
    output logic [7:0] count_val
);
    logic [7:0] cells [REG_COUNT];

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_cell
        if (i == RO_IDX0) begin : g_id0
            assign cells[i] = RO_VAL0;
        end else if (i == RO_IDX1) begin : g_id1
            assign cells[i] = RO_VAL1;
        end else begin : g_rw
            localparam logic [7:0] INIT = (i == COUNT_IDX) ? COUNT_INIT : 8'h00;
            logic [7:0] cell_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                     cell_q <= INIT;
                else if (we && widx == 8'(i))   cell_q <= wdata;
            end
            assign cells[i] = cell_q;
        end
    end

    // indices with no cell behind them read as zero
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (rd_idx == 8'(i)) rd_data = cells[i];
        end
    end

    assign count_val = cells[COUNT_IDX];

endmodule

// File: rtl/i2cx_core.sv
module i2cx_core
    import i2cx_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR  = 7'h69,
    parameter int unsigned REG_COUNT = 24,
    parameter int unsigned RO_IDX0   = 6,
    parameter int unsigned RO_IDX1   = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    input  logic [7:0] count_val,
    output logic [7:0] rd_idx,
    output logic       sda_oe,
    output logic       we,
    output logic [7:0] widx,
    output logic [7:0] wdata
);
    core_s q, d;

    function automatic logic writable(input logic [7:0] i);
        return (32'(i) < REG_COUNT) && (32'(i) != RO_IDX0) && (32'(i) != RO_IDX1);
    endfunction

    logic [7:0] tx_next;
    assign rd_idx  = q.idx;
    assign tx_next = (q.rem != 8'd0) ? rd_data : 8'hFF;

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (stop_det) begin
            d.ph   = PH_IDLE;
            d.oe   = 1'b0;
            d.full = 1'b0;
        end else if (start_det) begin
            d.ph   = PH_ADDR;
            d.bitn = 3'd0;
            d.full = 1'b0;
            d.oe   = 1'b0;
        end else begin
            case (q.ph)
                PH_ADDR, PH_INDEX, PH_COUNT, PH_WDATA: begin
                    if (scl_rise && !q.full) begin
                        d.shreg = {q.shreg[6:0], sda_s};
                        d.bitn  = q.bitn + 3'd1;
                        if (q.bitn == 3'd7) d.full = 1'b1;
                    end else if (scl_fall && q.full) begin
                        d.full = 1'b0;
                        d.bitn = 3'd0;
                        d.ph   = PH_ACK;
                        d.oe   = 1'b1;
                        case (q.ph)
                            PH_ADDR: begin
                                if (q.shreg[7:1] != DEV_ADDR) begin
                                    d.ph = PH_SKIP;
                                    d.oe = 1'b0;
                                end else if (!q.shreg[0]) begin
                                    d.nxt_ph = PH_INDEX;
                                end else begin
                                    d.nxt_ph = PH_TX;
                                    d.shreg  = count_val;
                                    d.rem    = count_val;
                                end
                            end
                            PH_INDEX: begin
                                d.idx    = q.shreg;
                                d.nxt_ph = PH_COUNT;
                            end
                            PH_COUNT: begin
                                d.rem    = q.shreg;
                                d.nxt_ph = PH_WDATA;
                            end
                            default: begin
                                if (q.rem == 8'd0) begin
                                    d.ph = PH_SKIP;
                                    d.oe = 1'b0;
                                end else begin
                                    d.rem    = q.rem - 8'd1;
                                    d.idx    = q.idx + 8'd1;
                                    d.nxt_ph = PH_WDATA;
                                    if (writable(q.idx)) begin
                                        d.we    = 1'b1;
                                        d.widx  = q.idx;
                                        d.wdata = q.shreg;
                                    end
                                end
                            end
                        endcase
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        d.ph   = q.nxt_ph;
                        d.bitn = 3'd0;
                        d.oe   = (q.nxt_ph == PH_TX) ? ~q.shreg[7] : 1'b0;
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (q.bitn == 3'd7) begin
                            d.oe   = 1'b0;
                            d.ph   = PH_TXACK;
                            d.bitn = 3'd0;
                        end else begin
                            d.shreg = {q.shreg[6:0], 1'b0};
                            d.oe    = ~q.shreg[6];
                            d.bitn  = q.bitn + 3'd1;
                        end
                    end
                end
                PH_TXACK: begin
                    if (scl_rise && sda_s) begin
                        d.ph = PH_SKIP;
                    end else if (scl_fall) begin
                        d.shreg = tx_next;
                        d.oe    = ~tx_next[7];
                        d.ph    = PH_TX;
                        d.bitn  = 3'd0;
                        if (q.rem != 8'd0) begin
                            d.idx = q.idx + 8'd1;
                            d.rem = q.rem - 8'd1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe = q.oe;
    assign we     = q.we;
    assign widx   = q.widx;
    assign wdata  = q.wdata;

endmodule

// File: rtl/i2cx_regslave.sv
module i2cx_regslave #(
    parameter logic [6:0]  DEV_ADDR    = 7'h69,
    parameter int unsigned REG_COUNT   = 24,
    parameter int unsigned COUNT_IDX   = 8,
    parameter logic [7:0]  COUNT_INIT  = 8'h0F,
    parameter int unsigned RO_IDX0     = 6,
    parameter int unsigned RO_IDX1     = 7,
    parameter logic [7:0]  RO_VAL0     = 8'h01,
    parameter logic [7:0]  RO_VAL1     = 8'h28,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       reg_we,
    output logic [7:0] reg_widx,
    output logic [7:0] reg_wdata
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] rd_idx, rd_data, count_val;

    i2cx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cx_core #(
        .DEV_ADDR(DEV_ADDR), .REG_COUNT(REG_COUNT),
        .RO_IDX0(RO_IDX0), .RO_IDX1(RO_IDX1)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .count_val(count_val), .rd_idx(rd_idx),
        .sda_oe(sda_oe), .we(reg_we), .widx(reg_widx), .wdata(reg_wdata)
    );

    i2cx_regs #(
        .REG_COUNT(REG_COUNT), .COUNT_IDX(COUNT_IDX), .COUNT_INIT(COUNT_INIT),
        .RO_IDX0(RO_IDX0), .RO_IDX1(RO_IDX1), .RO_VAL0(RO_VAL0), .RO_VAL1(RO_VAL1)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .widx(reg_widx), .wdata(reg_wdata),
        .rd_idx(rd_idx), .rd_data(rd_data), .count_val(count_val)
    );

endmodule

// File: rtl/i2cx_checker.sv
module i2cx_checker #(
    parameter int unsigned REG_COUNT = 24,
    parameter int unsigned RO_IDX0   = 6,
    parameter int unsigned RO_IDX1   = 7
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       stop_det,
    input logic       sda_oe,
    input logic       reg_we,
    input logic [7:0] reg_widx
);
    // R1: bus released on the first clock out of reset
    a_r1_release_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sda_oe && !reg_we);

    // R14: the pull-low enable moves only in the SCL low phase
    a_r14_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R4: one strobe per byte, never two in a row
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R7 and R11: strobes only reach implemented, writable cells
    a_r7_strobe_target: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (32'(reg_widx) < REG_COUNT) && (32'(reg_widx) != RO_IDX0)
                   && (32'(reg_widx) != RO_IDX1));

    // R12: a STOP leaves the bus released and writes nothing
    a_r12_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe && !reg_we);

endmodule

bind i2cx_regslave i2cx_checker #(
    .REG_COUNT(REG_COUNT), .RO_IDX0(RO_IDX0), .RO_IDX1(RO_IDX1)
) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
    .sda_oe(sda_oe), .reg_we(reg_we), .reg_widx(reg_widx)
);

// File: tb/tb_i2cx_regslave.sv
module tb_i2cx_regslave;
    localparam int QT = 4;
    localparam int HT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic hsda = 1'b1;
    logic sda_oe, reg_we;
    logic [7:0] reg_widx, reg_wdata;
    wire  sda_line = hsda & ~sda_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int r14_bad = 0;

    logic [7:0]  mdl [256];
    logic [15:0] exp_q [$];

    always #4 clk = ~clk;

    i2cx_regslave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .reg_we(reg_we), .reg_widx(reg_widx), .reg_wdata(reg_wdata)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] mread(input int i);
        return (i < 24) ? mdl[i] : 8'h00;
    endfunction

    function automatic bit mwritable(input int i);
        return (i < 24) && (i != 6) && (i != 7);
    endfunction

    // R4: each strobe must match the next write predicted by the model
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R4: actual write %0h:%0h expected none", reg_widx, reg_wdata);
            end else begin
                check("R4 write strobe", {reg_widx, reg_wdata}, exp_q.pop_front());
            end
        end
    end

    // R14: watch the pull-low enable while the bus clock is high
    logic oe_prev = 1'b0;
    logic scl_prev = 1'b1;
    always @(negedge clk) begin
        if (rst_n && scl && scl_prev && (sda_oe != oe_prev)) r14_bad++;
        oe_prev  <= sda_oe;
        scl_prev <= scl;
    end

    task automatic start_c();
        hsda = 1'b1; scl = 1'b1; tick(QT);
        hsda = 1'b0; tick(QT);
        scl = 1'b0; tick(QT);
    endtask

    task automatic rstart_c();
        hsda = 1'b1; tick(QT);
        scl = 1'b1; tick(QT);
        hsda = 1'b0; tick(QT);
        scl = 1'b0; tick(QT);
    endtask

    task automatic stop_c();
        hsda = 1'b0; tick(QT);
        scl = 1'b1; tick(QT);
        hsda = 1'b1; tick(QT);
    endtask

    task automatic write_bit(input logic b);
        hsda = b; tick(QT);
        scl = 1'b1; tick(HT);
        scl = 1'b0; tick(QT);
    endtask

    task automatic read_bit(output logic b);
        hsda = 1'b1; tick(QT);
        scl = 1'b1; tick(HT / 2);
        b = sda_line; tick(HT / 2);
        scl = 1'b0; tick(QT);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        logic v;
        for (int i = 7; i >= 0; i--) write_bit(b[i]);
        read_bit(v);
        ack = !v;
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            read_bit(v);
            b[i] = v;
        end
        write_bit(!ack);
    endtask

    task automatic do_write(input string req, input int idx, input int cnt, input logic [7:0] dat [$]);
        bit ack;
        int p = idx;
        start_c();
        send_byte(8'hD2, ack);      check({req, " R2 addr ack"}, ack, 1);
        send_byte(idx[7:0], ack);   check({req, " R2 index ack"}, ack, 1);
        send_byte(cnt[7:0], ack);   check({req, " R2 count ack"}, ack, 1);
        foreach (dat[i]) begin
            if (i < cnt) begin
                if (mwritable(p)) begin
                    mdl[p] = dat[i];
                    exp_q.push_back({p[7:0], dat[i]});
                end
                p = (p + 1) % 256;
            end
            send_byte(dat[i], ack);
            check({req, " data ack"}, ack, (i < cnt) ? 1 : 0);
            if (i >= cnt) break;
        end
        stop_c();
        tick(4);
    endtask

    task automatic do_read(input string req, input int idx, input int n);
        bit ack;
        logic [7:0] b;
        int p = idx;
        int rem;
        start_c();
        send_byte(8'hD2, ack);      check({req, " R3 addr ack"}, ack, 1);
        send_byte(idx[7:0], ack);   check({req, " R3 index ack"}, ack, 1);
        rstart_c();
        send_byte(8'hD3, ack);      check({req, " R3 read addr ack"}, ack, 1);
        rem = mdl[8];
        recv_byte(n > 0, b);        check({req, " R3 count byte"}, b, mdl[8]);
        for (int k = 0; k < n; k++) begin
            logic [7:0] e;
            if (rem > 0) begin
                e = mread(p);
                p = (p + 1) % 256;
                rem--;
            end else begin
                e = 8'hFF;
            end
            recv_byte(k < n - 1, b);
            check({req, " data byte"}, b, e);
        end
        tick(2);
        check({req, " R13 released after NACK"}, sda_oe, 0);
        stop_c();
        tick(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] dq [$];
        bit ack;
        logic v;
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        mdl[6] = 8'h01; mdl[7] = 8'h28; mdl[8] = 8'h0F;

        tick(5);
        rst_n = 1'b1;
        tick(3);
        check("R1 sda_oe after reset", sda_oe, 0);
        check("R1 strobe after reset", reg_we, 0);

        // R5 R6: default count and identification bytes
        do_read("R5 R6 defaults", 6, 3);

        // R2 R3 R4: plain block write then read back
        dq = {8'hA5, 8'h3C, 8'h00, 8'hFF};
        do_write("R4 block write", 0, 4, dq);
        do_read("R3 readback", 0, 4);

        // R7: identification bytes ignore writes
        dq = {8'h77, 8'h99, 8'hAA};
        do_write("R7 id write", 5, 3, dq);
        do_read("R7 id readback", 5, 3);

        // R9: byte past the write count is refused
        dq = {8'h11, 8'h22, 8'h33};
        do_write("R9 overlong", 10, 2, dq);
        do_read("R9 readback", 10, 3);

        // R5 R8: shorter read count, then released tail
        dq = {8'h02};
        do_write("R5 set count", 8, 1, dq);
        do_read("R8 tail", 0, 4);

        // R10: foreign address
        start_c();
        send_byte(8'hA0, ack);     check("R10 foreign addr nack", ack, 0);
        send_byte(8'h00, ack);     check("R10 no ack after foreign", ack, 0);
        check("R10 sda released", sda_oe, 0);
        stop_c();
        tick(4);

        // R11: run off the end of the file, and wrap of the index
        dq = {8'h04};
        do_write("R11 set count", 8, 1, dq);
        dq = {8'h11, 8'h22, 8'h33, 8'h44};
        do_write("R11 past end", 22, 4, dq);
        do_read("R11 readback", 22, 4);
        dq = {8'h5A, 8'h6B};
        do_write("R11 wrap", 255, 2, dq);
        do_read("R11 wrap readback", 255, 2);

        // R12: STOP in the middle of a data byte
        start_c();
        send_byte(8'hD2, ack);     check("R12 addr ack", ack, 1);
        send_byte(8'h01, ack);     check("R12 index ack", ack, 1);
        send_byte(8'h01, ack);     check("R12 count ack", ack, 1);
        for (int i = 0; i < 4; i++) write_bit(1'b1);
        stop_c();
        tick(4);
        check("R12 idle after stop", sda_oe, 0);
        // R12: START while the count byte is expected restarts addressing
        start_c();
        send_byte(8'hD2, ack);     check("R12 addr ack 2", ack, 1);
        send_byte(8'h02, ack);     check("R12 index ack 2", ack, 1);
        start_c();
        send_byte(8'h00, ack);     check("R12 restarted addr nack", ack, 0);
        stop_c();
        tick(4);
        do_read("R12 readback", 1, 2);

        // R13: NACK right on the count byte, then bus stays released
        start_c();
        send_byte(8'hD2, ack);
        send_byte(8'h00, ack);
        rstart_c();
        send_byte(8'hD3, ack);     check("R13 read addr ack", ack, 1);
        begin
            logic [7:0] b;
            recv_byte(1'b0, b);    check("R13 count byte", b, mdl[8]);
        end
        read_bit(v);               check("R13 released bit", v, 1);
        stop_c();
        tick(4);

        check("R14 oe change with scl high", r14_bad, 0);
        check("R4 no pending writes", exp_q.size(), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule